// File: doc/BRIEF.md
# Composite Sync Separator

This block takes a digital composite sync stream (active-low pulses on a high idle level) and splits it into a horizontal sync output, a vertical sync output and a widened vertical pulse. On ordinary lines the horizontal output is the composite input delayed by one register stage. The block measures the line period between consecutive falling edges. A low pulse that stays low for longer than a threshold marks the start of the vertical interval, and the period in use at that moment is frozen.

During the vertical interval the composite input carries broad pulses instead of line pulses. The block replaces them on the horizontal output with pulses of its own, spaced by the frozen period. The vertical output goes low at the first composite falling edge at or after the first generated pulse. The interval ends when the input stays high for longer than a second threshold. The vertical output then returns high and the horizontal output follows the input again. The widened vertical output stays low for a fixed number of extra cycles after the vertical output has risen.

Top module: `csync_sep`

## Requirements
- R1: Outside the vertical interval, `hsync_o` equals `csync_i` delayed by one clock, and `vsync_o` and `vwide_o` are high.
- R2: A low run of at most LOW_TH (8) cycles is treated as a line pulse and leaves `vsync_o` high. A low run of LOW_TH+1 cycles starts the vertical interval.
- R3: The period is the number of cycles between two consecutive composite falling edges seen outside the vertical interval. The first falling edge after a vertical interval only re-arms the measurement. The latest value is frozen when a vertical interval starts.
- R4: From the start of the vertical pulse until the first period match, `hsync_o` still follows `csync_i` with one cycle of delay.
- R5: A period match occurs exactly one frozen period after the falling edge that opened the vertical pulse, and again every period after that. Each match drives `hsync_o` low for INS_W (2) cycles starting in the cycle after the match sample. Between matches `hsync_o` is high and ignores `csync_i`.
- R6: `vsync_o` goes low one cycle after the first composite falling edge sampled at or after the first match, and stays low until the vertical interval ends.
- R7: When `csync_i` is sampled high for HI_TH+1 (17) consecutive cycles inside the vertical interval, the interval ends. `vsync_o` is high and `hsync_o` follows `csync_i` again from the next cycle. A high run of exactly 16 cycles does not end the interval.
- R8: `vwide_o` is low whenever `vsync_o` is low, and for VEXT (19) further cycles after `vsync_o` rises.
- R9: While reset is asserted, all three outputs are high.
- R10: If the start of a vertical interval is detected before any period has been measured since reset, no pulses are generated and `vsync_o` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csync_i | input | 1 | Composite sync, active low |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| vwide_o | output | 1 | Widened vertical sync, active low |

## Verification
Plain lines at two periods show that the pass-through path works and that the frozen period follows the most recent line length. A line with an 8-cycle low pulse separates a long line pulse from a vertical pulse. Serrated vertical intervals come in three shapes. In the first, broad-pulse edges coincide with each match, so the vertical output must fall on the match sample. In the second, the gaps between broad pulses are exactly 16 cycles high, which tests the end-of-interval threshold. In the third, one overlong low pulse puts the first match in a low stretch, so the vertical output must wait for a later falling edge while generated pulses already appear. A vertical-length pulse right after reset, before any line has been measured, must pass through untouched.

// File: rtl/csep_pkg.sv
package csep_pkg;

  typedef enum logic [1:0] {
    ST_LINE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FILL  = 2'd2,
    ST_VACT  = 2'd3
  } sep_st_e;

endpackage

// File: rtl/csep_rst_sync.sv
module csep_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic srst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_no = sync_q[1];

endmodule

// File: rtl/csep_run_meter.sv
module csep_run_meter #(
  parameter int LOW_TH = 8,
  parameter int HI_TH  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  output logic fall_o,
  output logic long_low_o,
  output logic long_high_o
);

  localparam int MAXR  = (LOW_TH > HI_TH) ? LOW_TH : HI_TH;
  localparam int RUN_W = $clog2(MAXR + 2);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(MAXR + 1);

  logic             prev_q, prev_d;
  logic [RUN_W-1:0] lo_q, lo_d, hi_q, hi_d;

  always_comb begin
    prev_d = cs_i;
    lo_d   = '0;
    hi_d   = '0;
    if (cs_i) hi_d = (hi_q == RUN_SAT) ? hi_q : hi_q + 1'b1;
    else      lo_d = (lo_q == RUN_SAT) ? lo_q : lo_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      prev_q <= prev_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  assign fall_o      = prev_q & ~cs_i;
  assign long_low_o  = ~cs_i & (lo_q == RUN_W'(LOW_TH));
  assign long_high_o =  cs_i & (hi_q == RUN_W'(HI_TH));

endmodule

// File: rtl/csep_line_timer.sv
module csep_line_timer #(
  parameter int CNT_W = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic track_i,
  input  logic arm_clr_i,
  input  logic restart_i,
  output logic match_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] hcnt_q, hcnt_d, hreg_q, hreg_d;
  logic             hval_q, hval_d;
  logic             line_edge;

  assign line_edge = track_i & fall_i;

  always_comb begin
    hcnt_d = (hcnt_q == CNT_MAX) ? hcnt_q : hcnt_q + 1'b1;
    hreg_d = hreg_q;
    hval_d = hval_q;
    if (line_edge || restart_i) hcnt_d = CNT_W'(1);
    if (line_edge && hval_q)    hreg_d = hcnt_q;
    if (arm_clr_i)              hval_d = 1'b0;
    else if (line_edge)         hval_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      hreg_q <= '0;
      hval_q <= 1'b0;
    end else begin
      hcnt_q <= hcnt_d;
      hreg_q <= hreg_d;
      hval_q <= hval_d;
    end
  end

  assign match_o = (hreg_q != '0) && (hcnt_q == hreg_q);

  // R3: the measured period cannot move while the vertical interval runs
  a_r3_period_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !track_i |=> $stable(hreg_q));

endmodule

// File: rtl/csep_vwiden.sv
module csep_vwiden #(
  parameter int EXT = 19
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vs_next_i,
  output logic vw_o
);

  localparam int EW = $clog2(EXT + 1);

  logic [EW-1:0] ecnt_q, ecnt_d;
  logic          vw_q, vw_d;

  always_comb begin
    ecnt_d = '0;
    vw_d   = 1'b1;
    if (!vs_next_i) begin
      ecnt_d = EW'(EXT);
      vw_d   = 1'b0;
    end else if (ecnt_q != '0) begin
      ecnt_d = ecnt_q - 1'b1;
      vw_d   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ecnt_q <= '0;
      vw_q   <= 1'b1;
    end else begin
      ecnt_q <= ecnt_d;
      vw_q   <= vw_d;
    end
  end

  assign vw_o = vw_q;

endmodule

// File: rtl/csync_sep.sv
module csync_sep
  import csep_pkg::*;
#(
  parameter int LOW_TH = 8,
  parameter int HI_TH  = 16,
  parameter int INS_W  = 2,
  parameter int VEXT   = 19,
  parameter int CNT_W  = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csync_i,
  output logic hsync_o,
  output logic vsync_o,
  output logic vwide_o
);

  localparam int PW_W = $clog2(INS_W + 1);

  logic            srst_n;
  logic            fall_w, vdet_w, fin_w, match_w;
  logic            fire, ins_nx, in_vert;
  sep_st_e         st_q, st_d;
  logic [PW_W-1:0] pw_q, pw_d;
  logic            hs_q, hs_d, vs_q, vs_d;

  csep_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .srst_no (srst_n)
  );

  csep_run_meter #(.LOW_TH(LOW_TH), .HI_TH(HI_TH)) u_meter (
    .clk_i       (clk_i),
    .rst_ni      (srst_n),
    .cs_i        (csync_i),
    .fall_o      (fall_w),
    .long_low_o  (vdet_w),
    .long_high_o (fin_w)
  );

  assign in_vert = (st_q != ST_LINE);
  assign fire    = in_vert & match_w;

  csep_line_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (srst_n),
    .fall_i    (fall_w),
    .track_i   (~in_vert),
    .arm_clr_i (~in_vert & vdet_w),
    .restart_i (fire),
    .match_o   (match_w)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_LINE:  if (vdet_w) st_d = ST_ARMED;
      ST_ARMED: if (fin_w) st_d = ST_LINE;
                else if (match_w) st_d = fall_w ? ST_VACT : ST_FILL;
      ST_FILL:  if (fin_w) st_d = ST_LINE;
                else if (fall_w) st_d = ST_VACT;
      ST_VACT:  if (fin_w) st_d = ST_LINE;
      default:  st_d = ST_LINE;
    endcase
  end

  always_comb begin
    ins_nx = (st_d == ST_FILL) || (st_d == ST_VACT);
    pw_d   = '0;
    hs_d   = csync_i;
    if (ins_nx) begin
      if (fire) begin
        pw_d = PW_W'(INS_W - 1);
        hs_d = 1'b0;
      end else if (pw_q != '0) begin
        pw_d = pw_q - 1'b1;
        hs_d = 1'b0;
      end else begin
        hs_d = 1'b1;
      end
    end
    vs_d = (st_d != ST_VACT);
  end

  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n) begin
      st_q <= ST_LINE;
      pw_q <= '0;
      hs_q <= 1'b1;
      vs_q <= 1'b1;
    end else begin
      st_q <= st_d;
      pw_q <= pw_d;
      hs_q <= hs_d;
      vs_q <= vs_d;
    end
  end

  csep_vwiden #(.EXT(VEXT)) u_widen (
    .clk_i     (clk_i),
    .rst_ni    (srst_n),
    .vs_next_i (vs_d),
    .vw_o      (vwide_o)
  );

  assign hsync_o = hs_q;
  assign vsync_o = vs_q;

  // R1: on ordinary lines the horizontal output trails the input by one clock
  a_r1_pass_through: assert property (@(posedge clk_i) disable iff (!srst_n)
    ($past(srst_n) && st_q == ST_LINE) |-> (hsync_o == $past(csync_i)));

  // R2: the vertical interval can only open while the input is low
  a_r2_open_on_low: assert property (@(posedge clk_i) disable iff (!srst_n)
    (st_q != ST_LINE && $past(st_q) == ST_LINE) |-> !$past(csync_i));

  // R6: vertical output falls only on a composite falling edge
  a_r6_vs_on_edge: assert property (@(posedge clk_i) disable iff (!srst_n)
    $fell(vsync_o) |-> $past(fall_w));

  // R7: vertical output rises only after a long high run
  a_r7_vs_end_high: assert property (@(posedge clk_i) disable iff (!srst_n)
    $rose(vsync_o) |-> $past(fin_w));

  // R8: widened pulse covers the vertical pulse
  a_r8_cover: assert property (@(posedge clk_i) disable iff (!srst_n)
    !vsync_o |-> !vwide_o);

  // R8: widened pulse outlasts the vertical pulse
  a_r8_tail: assert property (@(posedge clk_i) disable iff (!srst_n)
    $rose(vsync_o) |-> !vwide_o);

endmodule

// File: tb/csync_sep_tb_top.sv
module csync_sep_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync = 1'b1;
  logic hs, vs, vw;

  always #2 clk = ~clk;

  csync_sep dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .csync_i (csync),
    .hsync_o (hs),
    .vsync_o (vs),
    .vwide_o (vw)
  );

  typedef struct {
    int    c;
    logic  h, v, w;
    string th, tv, tw;
  } exp_t;

  exp_t  q[$];
  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  bit    done = 0;
  int    v_at = -100000, per = 1, vs_from = -100000, n_at = -100000;
  string base_tag = "R1";
  string ins_tag = "R5";
  string vs_tag = "R6";

  task automatic chk(string tag, int c, string nm, logic a, logic e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s cyc=%0d %s actual=%b expected=%b", tag, c, nm, a, e);
    end
  endtask

  // driver: applies one input sample and queues the expected outputs
  task automatic drive(logic lvl);
    exp_t e;
    int   c;
    bit   ins;
    @(negedge clk);
    csync = lvl;
    c   = cyc;
    ins = (c >= v_at + per) && (c <= n_at + 18);
    e.c = c;
    e.h = ins ? !(((c - v_at) % per) < 2) : lvl;
    if (ins)                                e.th = ins_tag;
    else if (c >= v_at && c < v_at + per)   e.th = "R4";
    else if (c >= n_at + 19 && c < n_at + 40) e.th = "R7";
    else                                    e.th = base_tag;
    e.v  = !(c >= vs_from && c <= n_at + 18);
    e.tv = (c >= vs_from - 2 && c <= n_at + 20) ? vs_tag : base_tag;
    e.w  = !(c >= vs_from && c <= n_at + 37);
    e.tw = (c >= vs_from && c <= n_at + 40) ? "R8" : base_tag;
    q.push_back(e);
    cyc++;
  endtask

  task automatic seg(logic lvl, int len);
    for (int i = 0; i < len; i++) drive(lvl);
  endtask

  task automatic line(int p, int lo);
    seg(1'b0, lo);
    seg(1'b1, p - lo);
  endtask

  task automatic vert(int p, int nb, int lo);
    v_at    = cyc;
    per     = p;
    vs_from = cyc + p;
    n_at    = cyc + nb * p;
    for (int i = 0; i < nb; i++) line(p, lo);
  endtask

  // monitor: compares each queued item just after the edge that produced it
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.th, e.c, "hsync", hs, e.h);
        chk(e.tv, e.c, "vsync", vs, e.v);
        chk(e.tw, e.c, "vwide", vw, e.w);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R9", -1, "hsync", hs, 1'b1);
    chk("R9", -1, "vsync", vs, 1'b1);
    chk("R9", -1, "vwide", vw, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: vertical-length pulse before any period is known
    base_tag = "R10";
    seg(1'b0, 20);
    seg(1'b1, 20);

    // R1 / R2: plain lines, one with an 8-cycle low pulse
    base_tag = "R1";
    line(40, 3);
    line(40, 3);
    base_tag = "R2";
    line(40, 8);
    base_tag = "R1";
    line(40, 3);
    line(40, 3);

    // R5 / R6: broad pulses aligned with every match
    ins_tag = "R5";
    vs_tag  = "R6";
    vert(40, 3, 34);
    line(40, 3);
    line(40, 3);

    // R3 / R7: period changes to 30, serration highs of exactly 16
    for (int i = 0; i < 4; i++) line(30, 3);
    ins_tag = "R3";
    vs_tag  = "R7";
    vert(30, 2, 14);
    for (int i = 0; i < 3; i++) line(30, 3);

    // R5 / R6: first match falls inside a low stretch
    ins_tag = "R5";
    vs_tag  = "R6";
    v_at    = cyc;
    per     = 30;
    vs_from = cyc + 55;
    n_at    = cyc + 90;
    seg(1'b0, 45);
    seg(1'b1, 10);
    seg(1'b0, 20);
    seg(1'b1, 15);
    for (int i = 0; i < 3; i++) line(30, 3);

    repeat (4) @(posedge clk);
    #2;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule